// File: doc/BRIEF.md
# Accumulation Period Down Counter

This block decides how long a spectrum accumulation runs. Software first writes a preset count and picks one of two decrement sources. In event-count mode the counter steps down once for every accepted conversion event. In elapsed-time mode it steps down on a periodic tick that a prescaler derives from the system clock. The default ratio of 16 system clocks per tick gives about 3.2 µs per step at a 5 MHz clock, so a full 16-bit preset spans roughly 210 ms.

An arm command starts a run. While the run is active the block holds the accumulation enable high. When the count steps from one to zero, the block drops the enable, sets a sticky completion flag and issues a one-cycle abort pulse, all in the same cycle. The abort pulse returns the acquisition sequencer to idle wherever it is. Preset, source and arm commands take effect only while the counter is idle, so a run cannot be disturbed once it has started.

Top module: `acc_period_counter`

## Requirements
- R1: After reset, acq_en, done_flag and seq_abort are 0 and remaining is 0.
- R2: A load_cmd while acq_en is low sets remaining to load_value at the next clock and clears done_flag. A load_cmd while acq_en is high has no effect.
- R3: A mode_cmd while acq_en is low stores mode_sel as the decrement source (0 = event count, 1 = elapsed time). A mode_cmd while acq_en is high is ignored.
- R4: An arm_cmd while acq_en is low, with a nonzero preset, raises acq_en at the next clock. The preset is the load_value of a load_cmd in the same cycle, or otherwise the current remaining value. An arm_cmd while acq_en is high is ignored.
- R5: In event-count mode, each cycle in which event_pulse is high while acq_en is high lowers remaining by exactly one at the next clock. Event pulses while acq_en is low change nothing.
- R6: In elapsed-time mode, remaining falls by one every PRESCALE_DIV clocks. The first step comes PRESCALE_DIV clocks after acq_en rises, and event_pulse has no effect.
- R7: The step that takes remaining from 1 to 0 clears acq_en, sets done_flag and raises seq_abort for one cycle, all at the same clock edge.
- R8: An arm_cmd with a preset of zero leaves acq_en low and sets done_flag and seq_abort at the next clock.
- R9: done_flag stays set until a load_cmd or arm_cmd is accepted. It is never set while acq_en is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_cmd | input | 1 | Single-cycle command to take load_value as the preset |
| load_value | input | CNT_W | Preset count |
| mode_cmd | input | 1 | Single-cycle command to store mode_sel |
| mode_sel | input | 1 | Decrement source: 0 event count, 1 elapsed time |
| arm_cmd | input | 1 | Single-cycle command to start a run |
| event_pulse | input | 1 | One accepted conversion event per high cycle |
| acq_en | output | 1 | Accumulation enable, high while a run is active |
| done_flag | output | 1 | Sticky completion flag |
| seq_abort | output | 1 | One-cycle pulse that resets the acquisition sequencer |
| remaining | output | CNT_W | Counts left in the current run |

## Verification
Event-count runs are driven with sparse pseudo-random pulses and with back-to-back pulses. Sparse pulses separate stepping-on-event from stepping-on-cycle. Back-to-back pulses expose an off-by-one at the final step. An elapsed-time run is driven with event pulses present throughout, which shows whether the source select truly gates the events out and whether the first tick lands on the right cycle. Load, mode and arm commands issued mid-run, a zero preset, and a load and arm in the same cycle separate the idle-only command rules and the terminal handling from the plain count path.

// File: rtl/acp_pkg.sv
package acp_pkg;
  typedef enum logic {
    SRC_EVENTS = 1'b0,
    SRC_TIME   = 1'b1
  } tick_src_e;

  function automatic logic src_is_time(input tick_src_e s);
    return s == SRC_TIME;
  endfunction
endpackage

// File: rtl/acp_prescaler.sv
module acp_prescaler #(
  parameter int DIV_RATIO = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int PW = (DIV_RATIO > 1) ? $clog2(DIV_RATIO) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV_RATIO - 1);

  generate
    if (DIV_RATIO <= 1) begin : g_passthru
      logic unused_ok;
      assign unused_ok = clk ^ rst_n;
      assign tick = run;
    end else begin : g_divide
      logic [PW-1:0] phase_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          phase_q <= '0;
        else if (!run)
          phase_q <= '0;
        else if (phase_q == LAST)
          phase_q <= '0;
        else
          phase_q <= phase_q + 1'b1;
      end

      assign tick = run && (phase_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/acp_downcount.sv
module acp_downcount #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  input  logic             step_en,
  output logic [CNT_W-1:0] count_q
);
  function automatic logic [CNT_W-1:0] dec_one(input logic [CNT_W-1:0] v);
    return v - CNT_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      count_q <= '0;
    else if (load_en)
      count_q <= load_val;
    else if (step_en)
      count_q <= dec_one(count_q);
  end
endmodule

// File: rtl/acp_ctrl.sv
module acp_ctrl
  import acp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_cmd,
  input  logic [CNT_W-1:0] load_value,
  input  logic             mode_cmd,
  input  logic             mode_sel,
  input  logic             arm_cmd,
  input  logic             event_pulse,
  input  logic             presc_tick,
  input  logic [CNT_W-1:0] count,
  output logic             load_accept,
  output logic             arm_accept,
  output logic             step_en,
  output logic             finish_evt,
  output logic             zero_arm,
  output logic             run_q,
  output logic             done_q,
  output logic             abort_q,
  output tick_src_e        mode_q
);
  function automatic logic is_final(input logic [CNT_W-1:0] v);
    return v == CNT_W'(1);
  endfunction

  logic [CNT_W-1:0] preset_eff;
  logic             start_run;

  assign load_accept = load_cmd && !run_q;
  assign arm_accept  = arm_cmd && !run_q;
  assign preset_eff  = load_accept ? load_value : count;
  assign zero_arm    = arm_accept && (preset_eff == '0);
  assign start_run   = arm_accept && (preset_eff != '0);
  assign step_en     = run_q && (src_is_time(mode_q) ? presc_tick : event_pulse);
  assign finish_evt  = step_en && is_final(count);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= SRC_EVENTS;
    end else if (mode_cmd && !run_q) begin
      mode_q <= tick_src_e'(mode_sel);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      done_q  <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      abort_q <= finish_evt || zero_arm;
      if (start_run)
        run_q <= 1'b1;
      else if (finish_evt)
        run_q <= 1'b0;
      if (finish_evt || zero_arm)
        done_q <= 1'b1;
      else if (load_accept || arm_accept)
        done_q <= 1'b0;
    end
  end
endmodule

// File: rtl/acc_period_counter.sv
module acc_period_counter
  import acp_pkg::*;
#(
  parameter int CNT_W        = 16,
  parameter int PRESCALE_DIV = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_cmd,
  input  logic [CNT_W-1:0] load_value,
  input  logic             mode_cmd,
  input  logic             mode_sel,
  input  logic             arm_cmd,
  input  logic             event_pulse,
  output logic             acq_en,
  output logic             done_flag,
  output logic             seq_abort,
  output logic [CNT_W-1:0] remaining
);
  logic             load_accept;
  logic             arm_accept;
  logic             step_en;
  logic             finish_evt;
  logic             zero_arm;
  logic             presc_tick;
  logic             run_q;
  logic             done_q;
  logic             abort_q;
  tick_src_e        mode_q;
  logic [CNT_W-1:0] count_q;

  acp_prescaler #(.DIV_RATIO(PRESCALE_DIV)) u_presc (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run_q),
    .tick (presc_tick)
  );

  acp_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_cmd   (load_cmd),
    .load_value (load_value),
    .mode_cmd   (mode_cmd),
    .mode_sel   (mode_sel),
    .arm_cmd    (arm_cmd),
    .event_pulse(event_pulse),
    .presc_tick (presc_tick),
    .count      (count_q),
    .load_accept(load_accept),
    .arm_accept (arm_accept),
    .step_en    (step_en),
    .finish_evt (finish_evt),
    .zero_arm   (zero_arm),
    .run_q      (run_q),
    .done_q     (done_q),
    .abort_q    (abort_q),
    .mode_q     (mode_q)
  );

  acp_downcount #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_en (load_accept),
    .load_val(load_value),
    .step_en (step_en),
    .count_q (count_q)
  );

  assign acq_en    = run_q;
  assign done_flag = done_q;
  assign seq_abort = abort_q;
  assign remaining = count_q;
endmodule

// File: rtl/acp_checker.sv
module acp_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acq_en,
  input logic             done_flag,
  input logic             seq_abort,
  input logic [CNT_W-1:0] remaining,
  input logic             mode_q,
  input logic             presc_tick
);
  // R7: the falling edge of the enable comes with done, abort and a zero count
  a_r7_stop_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(acq_en) |-> (done_flag && seq_abort && remaining == '0));

  // R7: an abort pulse only accompanies a completed, idle counter
  a_r7_abort_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    seq_abort |-> (done_flag && !acq_en));

  // R8: done never rises without an abort pulse
  a_r8_done_rise_aborts: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_flag) |-> seq_abort);

  // R9: done and an active run are exclusive
  a_r9_done_excludes_run: assert property (@(posedge clk) disable iff (!rst_n)
    done_flag |-> !acq_en);

  // R4: a running counter never holds zero
  a_r4_run_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    acq_en |-> remaining != '0);

  // R5: while running the count either holds or drops by one
  a_r5_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    acq_en |=> (remaining == $past(remaining) ||
                remaining == $past(remaining) - CNT_W'(1)));

  // R3: the source select is frozen during a run
  a_r3_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    acq_en |=> $stable(mode_q));

  // R6: in elapsed-time mode the count moves only on a prescaler tick
  a_r6_time_ticks_only: assert property (@(posedge clk) disable iff (!rst_n)
    (acq_en && mode_q && !presc_tick) |=> $stable(remaining));
endmodule

bind acc_period_counter acp_checker #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .acq_en    (acq_en),
  .done_flag (done_flag),
  .seq_abort (seq_abort),
  .remaining (remaining),
  .mode_q    (mode_q),
  .presc_tick(presc_tick)
);

// File: tb/acc_period_counter_bench.sv
module acc_period_counter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W   = 16;
  localparam int DIV = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         load_cmd = 1'b0;
  logic [W-1:0] load_value = '0;
  logic         mode_cmd = 1'b0;
  logic         mode_sel = 1'b0;
  logic         arm_cmd = 1'b0;
  logic         event_pulse = 1'b0;
  logic         acq_en, done_flag, seq_abort;
  logic [W-1:0] remaining;

  int    n_vec = 0;
  int    n_bad = 0;
  string cur_req = "R1";
  bit    started = 1'b0;
  int    lfsr = 32'h1ACE;

  // behavioural reference state
  int m_run = 0, m_done = 0, m_abort = 0, m_rem = 0, m_mode = 0, m_age = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_period_counter #(.CNT_W(W), .PRESCALE_DIV(DIV)) u_acc_period_counter (
    .clk(clk), .rst_n(rst_n), .load_cmd(load_cmd), .load_value(load_value),
    .mode_cmd(mode_cmd), .mode_sel(mode_sel), .arm_cmd(arm_cmd),
    .event_pulse(event_pulse), .acq_en(acq_en), .done_flag(done_flag),
    .seq_abort(seq_abort), .remaining(remaining)
  );

  // reference model: advances on every rising edge from the sampled inputs
  always @(posedge clk) begin
    int idle, take_load, take_arm, preset, stepped, ended, zero_start;
    started = 1'b1;
    if (!rst_n) begin
      m_run = 0; m_done = 0; m_abort = 0; m_rem = 0; m_mode = 0; m_age = 0;
    end else begin
      idle       = (m_run == 0);
      take_load  = idle && load_cmd;
      take_arm   = idle && arm_cmd;
      preset     = take_load ? int'(load_value) : m_rem;
      stepped    = 0;
      if (!idle) begin
        m_age = m_age + 1;
        if (m_mode == 1) stepped = ((m_age % DIV) == 0);
        else             stepped = event_pulse;
      end
      ended      = stepped && (m_rem == 1);
      zero_start = take_arm && (preset == 0);
      m_abort    = ended || zero_start;
      if (ended || zero_start)      m_done = 1;
      else if (take_load || take_arm) m_done = 0;
      if (take_arm && preset != 0) begin
        m_run = 1; m_age = 0;
      end else if (ended) begin
        m_run = 0;
      end
      if (take_load)    m_rem = preset;
      else if (stepped) m_rem = (m_rem - 1) & 16'hFFFF;
      if (idle && mode_cmd) m_mode = mode_sel;
    end
  end

  // every-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (started) begin
      bit bad;
      bad = 1'b0;
      n_vec++;
      if (acq_en !== m_run[0]) begin
        bad = 1'b1;
        $display("FAIL %s acq_en actual=%0b expected=%0d t=%0t", cur_req, acq_en, m_run, $time);
      end
      if (done_flag !== m_done[0]) begin
        bad = 1'b1;
        $display("FAIL %s done_flag actual=%0b expected=%0d t=%0t", cur_req, done_flag, m_done, $time);
      end
      if (seq_abort !== m_abort[0]) begin
        bad = 1'b1;
        $display("FAIL %s seq_abort actual=%0b expected=%0d t=%0t", cur_req, seq_abort, m_abort, $time);
      end
      if (remaining !== W'(m_rem)) begin
        bad = 1'b1;
        $display("FAIL %s remaining actual=%0d expected=%0d t=%0t", cur_req, remaining, m_rem, $time);
      end
      if (bad) n_bad++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_load(input int v);
    load_cmd = 1'b1; load_value = W'(v); cyc(1); load_cmd = 1'b0;
  endtask

  task automatic pulse_mode(input bit s);
    mode_cmd = 1'b1; mode_sel = s; cyc(1); mode_cmd = 1'b0;
  endtask

  task automatic pulse_arm();
    arm_cmd = 1'b1; cyc(1); arm_cmd = 1'b0;
  endtask

  task automatic rand_events(input int n);
    for (int i = 0; i < n; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      event_pulse = lfsr[3] & lfsr[7];
      cyc(1);
    end
    event_pulse = 1'b0;
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    cyc(4);
    // R1: reset values
    chk(acq_en == 0 && done_flag == 0 && seq_abort == 0, "R1", "reset outputs",
        {acq_en, done_flag, seq_abort}, 0);
    chk(remaining == 0, "R1", "reset remaining", remaining, 0);
    rst_n = 1'b1;
    cyc(2);

    // R5: events while idle are ignored
    cur_req = "R5";
    event_pulse = 1'b1; cyc(3); event_pulse = 1'b0;
    chk(remaining == 0 && acq_en == 0, "R5", "idle events ignored", remaining, 0);

    // R2: load while idle
    cur_req = "R2";
    pulse_load(5);
    chk(remaining == 5, "R2", "load value", remaining, 5);

    // R3 / R4: event source, then arm
    cur_req = "R4";
    pulse_mode(1'b0);
    pulse_arm();
    chk(acq_en == 1, "R4", "acq_en after arm", acq_en, 1);

    // R2 / R3 / R4: commands during a run are ignored
    cur_req = "R3";
    load_cmd = 1'b1; load_value = 16'd9; mode_cmd = 1'b1; mode_sel = 1'b1; arm_cmd = 1'b1;
    cyc(1);
    load_cmd = 1'b0; mode_cmd = 1'b0; arm_cmd = 1'b0;
    chk(remaining == 5 && acq_en == 1, "R2", "mid-run load ignored", remaining, 5);

    // R5 / R7: sparse events until completion
    cur_req = "R5";
    rand_events(60);
    cur_req = "R7";
    chk(done_flag == 1 && acq_en == 0 && remaining == 0, "R7", "event run complete",
        {done_flag, acq_en}, 2);

    // R9: sticky done
    cur_req = "R9";
    event_pulse = 1'b1; cyc(10); event_pulse = 1'b0;
    chk(done_flag == 1, "R9", "done held", done_flag, 1);

    // R8: zero preset
    cur_req = "R8";
    pulse_load(0);
    chk(done_flag == 0, "R9", "load clears done", done_flag, 0);
    pulse_arm();
    chk(done_flag == 1 && acq_en == 0 && seq_abort == 1, "R8", "zero preset completes",
        {done_flag, acq_en, seq_abort}, 5);
    cyc(1);
    chk(seq_abort == 0, "R7", "abort one cycle", seq_abort, 0);

    // R4: load and arm in the same cycle, back-to-back events
    cur_req = "R4";
    load_cmd = 1'b1; load_value = 16'd3; arm_cmd = 1'b1; cyc(1);
    load_cmd = 1'b0; arm_cmd = 1'b0;
    chk(acq_en == 1 && remaining == 3, "R4", "same-cycle load and arm", remaining, 3);
    cur_req = "R7";
    event_pulse = 1'b1; cyc(3); event_pulse = 1'b0;
    chk(done_flag == 1 && remaining == 0, "R7", "back-to-back finish", remaining, 0);
    cyc(2);

    // R6: elapsed-time mode with events present
    cur_req = "R6";
    pulse_mode(1'b1);
    pulse_load(4);
    pulse_arm();
    event_pulse = 1'b1; cyc(DIV - 1);
    chk(remaining == 4, "R6", "no step before first tick", remaining, 4);
    cyc(1);
    chk(remaining == 3, "R6", "first tick step", remaining, 3);
    rand_events(3 * DIV + 5);
    chk(done_flag == 1 && acq_en == 0, "R6", "time run complete", done_flag, 1);

    // R5: single-count preset and a long continuous run
    cur_req = "R5";
    pulse_mode(1'b0);
    pulse_load(1);
    pulse_arm();
    event_pulse = 1'b1; cyc(1); event_pulse = 1'b0;
    chk(done_flag == 1 && remaining == 0, "R7", "preset one finishes", remaining, 0);
    pulse_load(200);
    pulse_arm();
    event_pulse = 1'b1; cyc(150); event_pulse = 1'b0;
    chk(remaining == 50, "R5", "continuous events", remaining, 50);
    rand_events(300);
    cyc(3);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule